// File: doc/BRIEF.md
# Toggle-Serviced Watchdog Timer

This block watches one general-purpose line driven by a processor and raises a fault flag when the line has been still for too long. The processor services the watchdog by changing the line's level. A change from low to high counts as service, and so does a change from high to low. The allowed quiet time is the product of a fixed prescaler length, in clock cycles, and a programmable tick count on the `period` input.

When the quiet time runs out, the active-low `fault_n` output drops. It is meant for a non-maskable interrupt input. It then stays low until the line changes again or the system reset is applied. There is no timed pulse.

While the supervisor's synchronized active-low reset is asserted, the whole timer is held idle and `fault_n` is forced high. Releasing reset starts a fresh period.

Top module: `toggle_watchdog`

## Requirements
- R1: Either a rising or a falling change of `wd_line` restarts the full watchdog period. Periodic toggling at intervals shorter than the period therefore keeps `fault_n` high indefinitely.
- R2: If no change is detected, `fault_n` goes low exactly N*PRESCALE clock edges after the counters restart. N is the effective tick count.
- R3: Once low, `fault_n` stays low for as long as `wd_line` is unchanged.
- R4: While `rst_n` is low, `fault_n` is high (asynchronously on assertion) and the timer does not advance.
- R5: After `rst_n` rises, `fault_n` falls at exactly the N*PRESCALE-th rising clock edge, unless the line toggles first.
- R6: A `period` value of 0 is taken as N = 1. Any other value v gives N = v.
- R7: A change that clears a latched fault also restarts a full period. The next fault follows N*PRESCALE edges after the clearing edge.
- R8: When a detected change and a timeout fall in the same cycle, the change wins: `fault_n` stays high and a new period starts.
- R9: `wd_line` passes through a two-flop synchronizer and a previous-sample comparison. A change made between two clock edges takes effect at the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronized active-low system reset; async assert |
| wd_line | input | 1 | Processor line that services the watchdog by toggling |
| period | input | PERIOD_W | Watchdog period in prescaler ticks (0 treated as 1) |
| fault_n | output | 1 | Active-low latched watchdog fault |

## Verification
A fault in this block shows at `fault_n` as one of three things: a fall that comes a few edges early or late, a fall that never happens, or a fall that is not cleared by a toggle. Each of these is visible within one watchdog period of the stimulus. A stuck or miscounted prescaler or tick counter shifts the measured fall edge by PRESCALE cycles or more. The bench therefore measures that edge exactly, rather than just checking that a fall occurs. A wrong priority between a change and a timeout, or a synchronizer of the wrong depth, moves `fault_n` within three edges of a toggle. This is checked cycle by cycle around each toggle.

// File: rtl/wd_pkg.sv
package wd_pkg;

  typedef enum logic {
    WD_ARMED   = 1'b0,
    WD_TRIPPED = 1'b1
  } wd_state_e;

  // Effective tick count: a zero request is raised to the minimum of one.
  function automatic int unsigned wd_eff_ticks(input int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

  // Total clock cycles from a restart to the timeout cycle boundary.
  function automatic int unsigned wd_window_cycles(input int unsigned raw,
                                                   input int unsigned prescale);
    return wd_eff_ticks(raw) * prescale;
  endfunction

endpackage

// File: rtl/wd_edge_sync.sv
module wd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_evt
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  // Any difference between the settled sample and its predecessor is service.
  assign edge_evt = sync_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/wd_prescaler.sv
module wd_prescaler #(
  parameter int PRESCALE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);

  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  generate
    if (PRESCALE == 1) begin : g_passthru
      assign tick = 1'b1;
    end else begin : g_count
      localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
      logic [CW-1:0] cnt_q;

      assign tick = (cnt_q == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clr)     cnt_q <= '0;
        else if (tick)    cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/wd_tick_counter.sv
module wd_tick_counter
  import wd_pkg::*;
#(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                tick,
  input  logic [PERIOD_W-1:0] limit,
  output logic                timeout
);

  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W-1:0] last_idx;

  assign last_idx = PERIOD_W'(wd_eff_ticks(32'(limit)) - 1);
  assign timeout  = tick && (cnt_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/toggle_watchdog.sv
module toggle_watchdog
  import wd_pkg::*;
#(
  parameter int PRESCALE    = 16,
  parameter int PERIOD_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wd_line,
  input  logic [PERIOD_W-1:0] period,
  output logic                fault_n
);

  logic      edge_evt;
  logic      tick;
  logic      timeout;
  logic      restart;
  wd_state_e state_q;

  wd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (wd_line),
    .edge_evt (edge_evt)
  );

  wd_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (restart),
    .tick  (tick)
  );

  wd_tick_counter #(.PERIOD_W(PERIOD_W)) u_ticks (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (restart),
    .tick    (tick),
    .limit   (period),
    .timeout (timeout)
  );

  // Service or expiry both rewind the timing chain to a fresh window.
  assign restart = edge_evt | timeout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         state_q <= WD_ARMED;
    else if (edge_evt)  state_q <= WD_ARMED;     // service beats expiry
    else if (timeout)   state_q <= WD_TRIPPED;
  end

  assign fault_n = (state_q != WD_TRIPPED);

endmodule

// File: rtl/wd_checker.sv
module wd_checker (
  input logic clk,
  input logic rst_n,
  input logic fault_n,
  input logic edge_evt,
  input logic tick,
  input logic timeout
);

  AST_RESET_HOLDS_HIGH: assert property (@(posedge clk)
    !rst_n |-> fault_n); // R4

  AST_FALL_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n) |-> $past(timeout)); // R2

  AST_EXPIRY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> tick); // R2

  AST_QUIET_EXPIRY_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !edge_evt) |=> !fault_n); // R2

  AST_FAULT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !edge_evt) |=> !fault_n); // R3

  AST_SERVICE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> fault_n); // R7

  AST_SERVICE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && timeout) |=> fault_n); // R8

endmodule

bind toggle_watchdog wd_checker u_wd_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .fault_n  (fault_n),
  .edge_evt (edge_evt),
  .tick     (tick),
  .timeout  (timeout)
);

// File: tb/toggle_watchdog_bench.sv
module toggle_watchdog_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PRESC      = 4;

  typedef struct packed {
    logic [7:0]  per;
    logic [15:0] cycles;   // expected edges from restart to fault
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{8'd1,   16'd4},
    '{8'd2,   16'd8},
    '{8'd5,   16'd20},
    '{8'd0,   16'd4},      // R6: zero behaves as one tick
    '{8'd17,  16'd68},
    '{8'd255, 16'd1020}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wd_line = 1'b0;
  logic [7:0] period = 8'd5;
  logic       fault_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  toggle_watchdog #(.PRESCALE(PRESC), .PERIOD_W(8), .SYNC_STAGES(2)) u_toggle_watchdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .wd_line (wd_line),
    .period  (period),
    .fault_n (fault_n)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n   = 1'b0;
    wd_line = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Counts rising edges until fault_n is seen low at a falling edge.
  task automatic wait_fall(output int n);
    n = 0;
    while (n < 5000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (!fault_n) break;
    end
  endtask

  task automatic toggle_and_check_clear(input string req);
    wd_line = ~wd_line;
    repeat (2) @(negedge clk);
    check({req, " still low before sync"}, int'(fault_n), 0);
    @(negedge clk);
    check({req, " cleared at third edge"}, int'(fault_n), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int lowseen;
    // Reset state, R4
    repeat (3) @(negedge clk);
    check("R4 reset state", int'(fault_n), 1);

    // Table walk: R2, R3, R5, R6, R7, R1, R9
    for (int i = 0; i < NVEC; i++) begin
      period = VEC[i].per;
      do_reset();
      wait_fall(n);
      check($sformatf("R5 R2 R6 first fall per=%0d", VEC[i].per), n, int'(VEC[i].cycles));
      repeat (20) @(negedge clk);
      check("R3 held low", int'(fault_n), 0);
      toggle_and_check_clear("R9 R7 rising");
      wait_fall(n);
      check($sformatf("R7 R1 rising restart per=%0d", VEC[i].per), n, int'(VEC[i].cycles));
      toggle_and_check_clear("R9 R1 falling");
      wait_fall(n);
      check($sformatf("R1 falling restart per=%0d", VEC[i].per), n, int'(VEC[i].cycles));
    end

    // R8: change detected in the timeout cycle
    period = 8'd5;
    do_reset();
    repeat (20 - 3) @(negedge clk);
    wd_line = ~wd_line;
    repeat (3) @(negedge clk);
    check("R8 coincident change keeps high", int'(fault_n), 1);
    wait_fall(n);
    check("R8 coincident change restarts", n, 20);

    // One cycle too late: timeout first, then cleared (R2, R3)
    do_reset();
    repeat (20 - 2) @(negedge clk);
    wd_line = ~wd_line;
    repeat (2) @(negedge clk);
    check("R2 late change, timeout trips", int'(fault_n), 0);
    @(negedge clk);
    check("R3 late change clears", int'(fault_n), 1);

    // R1: regular service never lets it trip
    do_reset();
    lowseen = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (k % 12 == 0) wd_line = ~wd_line;
      if (!fault_n) lowseen++;
    end
    check("R1 serviced no fault", lowseen, 0);

    // R4: reset mid-count and long hold, then R5 fresh period
    do_reset();
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    lowseen = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (!fault_n) lowseen++;
    end
    check("R4 held in reset", lowseen, 0);
    rst_n = 1'b1;
    wait_fall(n);
    check("R5 fresh period after release", n, 20);

    // R3: long quiet hold, then R4 reset while faulted
    lowseen = 0;
    for (int k = 0; k < 1500; k++) begin
      @(negedge clk);
      if (fault_n) lowseen++;
    end
    check("R3 long hold high samples", lowseen, 0);
    rst_n = 1'b0;
    #1;
    check("R4 async reset while faulted", int'(fault_n), 1);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule